// File: doc/BRIEF.md
# Card Bus Clock Controller

This block derives the serial clock for a memory card from a fast reference clock. Software picks a rate with a 3-bit code. It requests a start or a stop by writing one-shot command bits, and it reads back whether the card clock is running.

A stop is never abrupt. The controller waits until the current high phase of the card clock has run to its full length. It stops on that falling edge, clears the running flag and raises a clock-off interrupt. A start always begins from the idle low level. A new rate code is latched only at a falling edge, which is the point where each card-clock period begins, so no shortened high pulse ever reaches the card.

The register port has a write strobe with address and data, and a combinational read path selected by a separate read address. There are four registers:

| Address | Register | Access |
|---------|----------|--------|
| 0 | Command | write-only; bit 0 = stop, bit 1 = start |
| 1 | Rate | code in bits 2:0 |
| 2 | Status | bit 8 = running |
| 3 | Interrupt | bit 4 = clock-off; write 1 to clear |

Top module: `card_clk_ctrl`

## Requirements
- R1: After reset the card clock is low, the running flag is 0, the clock-off interrupt is 0 and the rate register (address 1, bits 2:0) reads 0.
- R2: Writing bit 1 to address 0 while stopped sets the running flag (output and status bit 8 at address 2) one cycle after the write edge. The card clock rises on the following edge.
- R3: For rate codes k = 0 to 6, each high phase and each low phase lasts BASE_HALF<<k reference cycles (2<<k by default).
- R4: Rate code 7 is the high-speed setting. Each high phase and each low phase lasts HS_HALF reference cycles (1 by default).
- R5: Writing bit 0 to address 0 while running stops the clock at the end of a full high phase. The running flag clears on the same edge as the card clock falls, and the clock then stays low.
- R6: A completed stop sets the clock-off interrupt: the output and bit 4 at address 3. Writing 1 to bit 4 of address 3 clears it.
- R7: A stop request while the clock is already stopped has no effect and raises no interrupt.
- R8: When bits 0 and 1 are written together, the stop wins. A running clock stops and does not restart, and a stopped clock stays stopped.
- R9: A rate code written during a high phase leaves that high phase at its old length. The new length applies from the next falling edge on.
- R10: The rate register keeps only bits 2:0 of the written value. Address 0 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DATA_W | Read data (combinational) |
| card_clk_o | output | 1 | Card clock |
| clk_en_o | output | 1 | Card clock running flag |
| clk_off_irq_o | output | 1 | Clock-off interrupt |

## Verification
The assertions assume three things about the inputs:
- the block starts from a clean reset;
- the write strobe, address and data are known, settled values at each reference edge;
- a command write is a single-cycle strobe.

The bench meets all three by driving every input on the falling reference edge, with one write per strobe and nothing driven during reset. Rate codes are drawn at random from the full 3-bit range. Directed sequences cover the cases that random draws reach rarely: a stop while stopped, a combined start and stop, and a rate change in the middle of a high phase.

// File: rtl/card_clk_pkg.sv
`timescale 1ns/1ps
package card_clk_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned RATE_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CMD  = 2'd0,
    REG_RATE = 2'd1,
    REG_STAT = 2'd2,
    REG_IRQ  = 2'd3
  } reg_addr_e;

  localparam int unsigned CMD_STOP_BIT  = 0;
  localparam int unsigned CMD_START_BIT = 1;
  localparam int unsigned STAT_RUN_BIT  = 8;
  localparam int unsigned IRQ_OFF_BIT   = 4;

  localparam logic [RATE_W-1:0] RATE_HS = '1;
endpackage

// File: rtl/card_clk_regs.sv
`timescale 1ns/1ps
module card_clk_regs
  import card_clk_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              run_i,
  input  logic              stop_done_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              irq_o,
  output logic              stop_req_o,
  output logic              start_req_o
);
  logic [RATE_W-1:0] rate_q;
  logic              irq_q;
  logic              unused_wr;

  assign unused_wr = ^{wr_data_i[DATA_W-1:IRQ_OFF_BIT+1], wr_data_i[IRQ_OFF_BIT-1:RATE_W]};

  // one-shot command strobes
  assign stop_req_o  = wr_en_i && (wr_addr_i == REG_CMD) && wr_data_i[CMD_STOP_BIT];
  assign start_req_o = wr_en_i && (wr_addr_i == REG_CMD) && wr_data_i[CMD_START_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
    end else if (wr_en_i && (wr_addr_i == REG_RATE)) begin
      rate_q <= wr_data_i[RATE_W-1:0];
    end
  end

  // a completed stop wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else if (stop_done_i) begin
      irq_q <= 1'b1;
    end else if (wr_en_i && (wr_addr_i == REG_IRQ) && wr_data_i[IRQ_OFF_BIT]) begin
      irq_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      REG_RATE: rd_data_o[RATE_W-1:0]   = rate_q;
      REG_STAT: rd_data_o[STAT_RUN_BIT] = run_i;
      REG_IRQ:  rd_data_o[IRQ_OFF_BIT]  = irq_q;
      default:  rd_data_o = '0;
    endcase
  end

  assign rate_o = rate_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/card_clk_run_ctl.sv
`timescale 1ns/1ps
module card_clk_run_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_req_i,
  input  logic start_req_i,
  input  logic fall_now_i,
  output logic run_o,
  output logic stop_done_o
);
  logic run_q, run_d;
  logic stop_pend_q, stop_pend_d;
  logic start_pend_q, start_pend_d;

  always_comb begin
    run_d        = run_q;
    stop_pend_d  = stop_pend_q;
    start_pend_d = start_pend_q;
    stop_done_o  = 1'b0;
    // a pending stop holds back any pending start
    if (stop_pend_q) begin
      if (!run_q) begin
        stop_pend_d = 1'b0;
      end else if (fall_now_i) begin
        run_d       = 1'b0;
        stop_pend_d = 1'b0;
        stop_done_o = 1'b1;
      end
    end else if (start_pend_q) begin
      start_pend_d = 1'b0;
      run_d        = 1'b1;
    end
    if (stop_req_i) begin
      stop_pend_d  = 1'b1;
      start_pend_d = 1'b0;
    end else if (start_req_i) begin
      start_pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q        <= 1'b0;
      stop_pend_q  <= 1'b0;
      start_pend_q <= 1'b0;
    end else begin
      run_q        <= run_d;
      stop_pend_q  <= stop_pend_d;
      start_pend_q <= start_pend_d;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/card_clk_div.sv
`timescale 1ns/1ps
module card_clk_div
  import card_clk_pkg::*;
#(
  parameter int unsigned BASE_HALF = 2,
  parameter int unsigned HS_HALF   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              card_clk_o,
  output logic              fall_now_o
);
  localparam int unsigned MAX_HALF = BASE_HALF << ((1 << RATE_W) - 2);
  localparam int unsigned TOP_HALF = (MAX_HALF > HS_HALF) ? MAX_HALF : HS_HALF;
  localparam int unsigned CNT_W    = $clog2(TOP_HALF + 1);

  logic [CNT_W-1:0] cnt_q, half_q, half_new;
  logic             ph_q;
  logic             term;

  always_comb begin
    if (rate_i == RATE_HS) half_new = CNT_W'(HS_HALF);
    else                   half_new = CNT_W'(BASE_HALF) << rate_i;
  end

  assign term       = (cnt_q == '0);
  assign fall_now_o = run_i && ph_q && term;

  // the half-period length is reloaded only at a falling edge or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      half_q <= CNT_W'(BASE_HALF);
    end else if (!run_i) begin
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      half_q <= half_new;
    end else if (term) begin
      if (ph_q) begin
        ph_q   <= 1'b0;
        half_q <= half_new;
        cnt_q  <= half_new - 1'b1;
      end else begin
        ph_q  <= 1'b1;
        cnt_q <= half_q - 1'b1;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign card_clk_o = ph_q;
endmodule

// File: rtl/card_clk_ctrl.sv
`timescale 1ns/1ps
module card_clk_ctrl
  import card_clk_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BASE_HALF = 2,
  parameter int unsigned HS_HALF   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              card_clk_o,
  output logic              clk_en_o,
  output logic              clk_off_irq_o
);
  logic [RATE_W-1:0] rate;
  logic              run, stop_done, stop_req, start_req, fall_now;

  card_clk_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_addr_i   (rd_addr_i),
    .run_i       (run),
    .stop_done_i (stop_done),
    .rd_data_o   (rd_data_o),
    .rate_o      (rate),
    .irq_o       (clk_off_irq_o),
    .stop_req_o  (stop_req),
    .start_req_o (start_req)
  );

  card_clk_run_ctl u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stop_req_i  (stop_req),
    .start_req_i (start_req),
    .fall_now_i  (fall_now),
    .run_o       (run),
    .stop_done_o (stop_done)
  );

  card_clk_div #(.BASE_HALF(BASE_HALF), .HS_HALF(HS_HALF)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .rate_i     (rate),
    .card_clk_o (card_clk_o),
    .fall_now_o (fall_now)
  );

  assign clk_en_o = run;
endmodule

// File: rtl/card_clk_ctrl_chk.sv
`timescale 1ns/1ps
module card_clk_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic stop_wr_i,
  input logic card_clk_o,
  input logic clk_en_o,
  input logic clk_off_irq_o
);
  a_r5_low_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> !card_clk_o);

  a_r5_stop_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_o) |-> $fell(card_clk_o));

  a_r6_irq_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_off_irq_o) |-> $fell(clk_en_o));

  a_r2_rise_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |=> card_clk_o);

  a_r7_idle_stop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_wr_i && !clk_en_o && !clk_off_irq_o) |=> !clk_off_irq_o);
endmodule

bind card_clk_ctrl card_clk_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .stop_wr_i     (wr_en_i && (wr_addr_i == 2'd0) && wr_data_i[0]),
  .card_clk_o    (card_clk_o),
  .clk_en_o      (clk_en_o),
  .clk_off_irq_o (clk_off_irq_o)
);

// File: tb/card_clk_ctrl_test.sv
`timescale 1ns/1ps
module card_clk_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        card_clk, clk_en, irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // edge monitor, sampled at posedge before the design updates
  logic prev_lvl = 1'b0;
  int   run_len = 0, last_hi = 0, last_lo = 0, fall_cnt = 0, rise_cnt = 0;

  card_clk_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .card_clk_o(card_clk), .clk_en_o(clk_en), .clk_off_irq_o(irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) begin
      if (card_clk != prev_lvl) begin
        if (prev_lvl) begin last_hi = run_len; fall_cnt++; end
        else          begin last_lo = run_len; rise_cnt++; end
        run_len  = 1;
        prev_lvl = card_clk;
      end else begin
        run_len++;
      end
    end
  end

  function automatic int exp_half(input int code);
    return (code == 7) ? 1 : (2 << code);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_falls(input int n);
    int tgt;
    int k;
    tgt = fall_cnt + n;
    k = 0;
    while (fall_cnt < tgt && k < 4000) begin @(negedge clk); k++; end
  endtask

  task automatic wait_stopped();
    int k;
    k = 0;
    while (clk_en && k < 2000) begin @(negedge clk); k++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    int rc, code, r0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(card_clk == 1'b0, "R1 card clock", card_clk, 0);
    check(clk_en == 1'b0, "R1 running flag", clk_en, 0);
    check(irq == 1'b0, "R1 interrupt", irq, 0);
    reg_read(2'd1, rv);
    check(rv == 0, "R1 rate reg", rv, 0);

    // R2 start timing, R3 code 0
    reg_write(2'd0, 32'h2);
    check(clk_en == 1'b0, "R2 not yet running", clk_en, 0);
    @(negedge clk);
    check(clk_en == 1'b1 && card_clk == 1'b0, "R2 running, clock low", {clk_en, card_clk}, 2);
    reg_read(2'd2, rv);
    check(rv == 32'h100, "R2 status bit 8", rv, 32'h100);
    @(negedge clk);
    check(card_clk == 1'b1, "R2 clock rises", card_clk, 1);
    wait_falls(2);
    check(last_hi == 2, "R3 code0 high", last_hi, 2);
    check(last_lo == 2, "R3 code0 low", last_lo, 2);

    // R5 stop, R6 interrupt
    reg_write(2'd0, 32'h1);
    wait_stopped();
    check(clk_en == 1'b0 && card_clk == 1'b0, "R5 stopped low", {clk_en, card_clk}, 0);
    check(last_hi == 2, "R5 last high full", last_hi, 2);
    check(irq == 1'b1, "R6 irq set", irq, 1);
    reg_read(2'd3, rv);
    check(rv == 32'h10, "R6 irq reg bit 4", rv, 32'h10);
    reg_read(2'd2, rv);
    check(rv == 0, "R5 status cleared", rv, 0);
    r0 = rise_cnt;
    repeat (10) @(negedge clk);
    check(card_clk == 1'b0 && rise_cnt == r0, "R5 stays low", rise_cnt - r0, 0);
    reg_write(2'd3, 32'h10);
    check(irq == 1'b0, "R6 irq cleared", irq, 0);

    // R7 stop while stopped
    reg_write(2'd0, 32'h1);
    repeat (5) @(negedge clk);
    check(irq == 1'b0 && clk_en == 1'b0, "R7 no effect", {clk_en, irq}, 0);

    // R8 both bits while stopped: stays stopped
    reg_write(2'd0, 32'h3);
    repeat (10) @(negedge clk);
    check(clk_en == 1'b0 && card_clk == 1'b0, "R8 idle stays stopped", clk_en, 0);

    // R4 high-speed code
    reg_write(2'd1, 32'h7);
    reg_write(2'd0, 32'h2);
    wait_falls(3);
    check(last_hi == 1 && last_lo == 1, "R4 high-speed halves", last_hi * 10 + last_lo, 11);

    // R8 both bits while running: stops, no restart
    reg_write(2'd0, 32'h3);
    wait_stopped();
    repeat (20) @(negedge clk);
    check(clk_en == 1'b0 && irq == 1'b1, "R8 running stops", {clk_en, irq}, 1);
    reg_write(2'd3, 32'h10);

    // R9 rate change during a high phase
    reg_write(2'd1, 32'h1);
    reg_write(2'd0, 32'h2);
    while (!card_clk) @(negedge clk);
    reg_write(2'd1, 32'h3);
    wait_falls(1);
    check(last_hi == 4, "R9 current high keeps old length", last_hi, 4);
    wait_falls(1);
    check(last_lo == 16 && last_hi == 16, "R9 new length after fall", last_lo, 16);
    reg_write(2'd0, 32'h1);
    wait_stopped();
    reg_write(2'd3, 32'h10);

    // R3/R4 random codes
    for (int i = 0; i < 12; i++) begin
      code = int'($urandom % 8);
      reg_write(2'd1, 32'(code));
      reg_write(2'd0, 32'h2);
      wait_falls(2);
      check(last_hi == exp_half(code), $sformatf("R3 code %0d high", code), last_hi, exp_half(code));
      check(last_lo == exp_half(code), $sformatf("R3 code %0d low", code), last_lo, exp_half(code));
      reg_write(2'd0, 32'h1);
      wait_stopped();
      check(irq == 1'b1, "R6 irq after random stop", irq, 1);
      reg_write(2'd3, 32'h10);
    end

    // R10 readback masking
    reg_write(2'd1, 32'hFFFF_FFFD);
    reg_read(2'd1, rv);
    check(rv == 5, "R10 rate keeps bits 2:0", rv, 5);
    reg_read(2'd0, rc);
    check(rc == 0, "R10 command reads 0", rc, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule